// File: doc/BRIEF.md
# Reduction Tree Node with Combining Unit

This block is one hop of a hardware reduction tree laid over a mesh. The tree follows dimension-ordered routing: contributions travel along X first, then along Y, toward a root node. Each node gathers its own local operand and the partial results of up to three neighbours that lie further from the root. A configuration input states how many contributions to expect. Once every expected contribution has arrived, the node folds them with the selected 32-bit integer operation. It then hands the single partial result to the next node toward the root or, if it is the root, delivers it on a local result port.

The combining unit covers signed maximum and minimum, wrap-around sum, bitwise AND/OR/XOR and logical AND/OR/XOR. The comparisons reuse the adder's subtraction. Any other operation code, including the user-defined code, puts the node in pass-through mode. In that mode it forwards every collected operand unchanged, one transfer each, so that the root can combine them centrally. All transfers use valid/ready handshakes. A node takes no new operands while a result of its own is still waiting to be accepted.

Top module: `red_node`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, both `up_valid` and `root_valid` are low.
- R2: Slot 0 is the local operand and slots 1 to 3 are neighbours. Only slots with index below the effective count raise `in_ready`. Each slot captures one operand and then keeps `in_ready` low until the node's output has been fully accepted. After that, the expected slots raise `in_ready` again. A valid on a slot that is not expected is never accepted and does not change the result.
- R3: No output appears before all expected operands have been captured. The output becomes valid exactly one clock edge after the edge that captures the last operand.
- R4: Arithmetic codes: 4'b0000 gives the signed maximum, 4'b0001 the signed minimum, and 4'b0010 the sum modulo 2^32.
- R5: Bitwise codes: 4'b0100 gives AND, 4'b0110 gives OR, and 4'b1001 gives XOR over all expected operands.
- R6: Logical codes treat any non-zero operand as true and give 32'd0 or 32'd1. 4'b0011 is true if all operands are true, 4'b0101 if any operand is true, and 4'b0111 if an odd number of operands are true.
- R7: For code 4'b1000 and codes 4'b1010 to 4'b1111, the node emits each captured operand unchanged, one per transfer, in slot order 0, 1, 2, 3.
- R8: With `cfg_root` high, results appear only on the root port. With `cfg_root` low, they appear only on the upstream port. The two valids are never high together.
- R9: While an output is valid and not accepted, it stays valid and its data stays stable.
- R10: An expected count of 0 is treated as 1, and a count above 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_count | input | 3 | Number of contributions expected (local plus neighbours) |
| cfg_root | input | 1 | Node is the root of the tree |
| cfg_op | input | 4 | Reduction operation code |
| in_valid | input | 4 | Operand valid per slot, slot 0 local |
| in_data | input | 128 | Operand data, slot g in bits [32g+31:32g] |
| in_ready | output | 4 | Operand ready per slot |
| up_valid | output | 1 | Result or raw operand valid toward the next node |
| up_data | output | 32 | Data toward the next node |
| up_ready | input | 1 | Next node accepts |
| root_valid | output | 1 | Final result valid at the root |
| root_data | output | 32 | Final result data at the root |
| root_ready | input | 1 | Local consumer accepts |

## Verification
The hardest case to reach is pass-through mode when the consumer applies back-pressure. There, several raw items leave one after another while the operand slots must stay closed, and each stalled item must hold its value. The bench reaches this case by issuing an unsupported code against a sink whose ready is high only one cycle in three. It does this with operands that arrive in a staggered order, so that capture order and emission order differ. A valid driven on a slot beyond the expected count covers the ignored-input case. The signed operand values are chosen so that signed and unsigned comparison give different answers.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [3:0] {
    OP_MAX  = 4'b0000,
    OP_MIN  = 4'b0001,
    OP_SUM  = 4'b0010,
    OP_LAND = 4'b0011,
    OP_BAND = 4'b0100,
    OP_LOR  = 4'b0101,
    OP_BOR  = 4'b0110,
    OP_LXOR = 4'b0111,
    OP_USER = 4'b1000,
    OP_BXOR = 4'b1001
  } rn_op_e;

  // codes the local combining unit can execute
  function automatic logic op_native(input logic [3:0] code);
    case (code)
      OP_MAX, OP_MIN, OP_SUM, OP_LAND, OP_BAND,
      OP_LOR, OP_BOR, OP_LXOR, OP_BXOR: op_native = 1'b1;
      default:                           op_native = 1'b0;
    endcase
  endfunction

  // codes that reduce truth values instead of bit patterns
  function automatic logic op_boolean(input logic [3:0] code);
    op_boolean = (code == OP_LAND) || (code == OP_LOR) || (code == OP_LXOR);
  endfunction

endpackage

// File: rtl/rn_slots.sv
module rn_slots #(
  parameter int NSLOT = 4,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  open_en,
  input  logic [NSLOT-1:0]      expect_mask,
  input  logic                  clear,
  input  logic [NSLOT-1:0]      in_valid,
  input  logic [NSLOT*DW-1:0]   in_data,
  output logic [NSLOT-1:0]      in_ready,
  output logic [NSLOT-1:0]      full_o,
  output logic [NSLOT*DW-1:0]   data_o
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic          full_q;
    logic [DW-1:0] dat_q;
    logic          take;

    assign in_ready[g] = open_en & expect_mask[g] & ~full_q;
    assign take        = in_valid[g] & in_ready[g];

    always_ff @(posedge clk) begin
      if (rst)        full_q <= 1'b0;
      else if (clear) full_q <= 1'b0;
      else if (take)  full_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (take) dat_q <= in_data[g*DW +: DW];
    end

    assign full_o[g]           = full_q;
    assign data_o[g*DW +: DW]  = dat_q;
  end

endmodule

// File: rtl/rn_rfu.sv
module rn_rfu
  import rn_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int DW    = 32,
  parameter int CW    = 3
) (
  input  logic [3:0]          op,
  input  logic [CW-1:0]       count_eff,
  input  logic [NSLOT*DW-1:0] opnd,
  output logic [DW-1:0]       res
);

  function automatic logic [DW-1:0] combine(input logic [3:0] code,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    logic [DW:0] diff;
    logic        a_lt_b;
    diff   = {a[DW-1], a} - {b[DW-1], b};
    a_lt_b = diff[DW];
    case (code)
      OP_MAX:           combine = a_lt_b ? b : a;
      OP_MIN:           combine = a_lt_b ? a : b;
      OP_SUM:           combine = a + b;
      OP_LAND, OP_BAND: combine = a & b;
      OP_LOR,  OP_BOR:  combine = a | b;
      OP_LXOR, OP_BXOR: combine = a ^ b;
      default:          combine = a;
    endcase
  endfunction

  logic [DW-1:0] norm [NSLOT];
  logic [DW-1:0] acc;
  logic          as_bool;

  assign as_bool = op_boolean(op);

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      if (as_bool) norm[i] = {{(DW-1){1'b0}}, |opnd[i*DW +: DW]};
      else         norm[i] = opnd[i*DW +: DW];
    end
    acc = norm[0];
    for (int i = 1; i < NSLOT; i++) begin
      if (CW'(i) < count_eff) acc = combine(op, acc, norm[i]);
    end
    res = acc;
  end

endmodule

// File: rtl/rn_emit.sv
module rn_emit #(
  parameter int NSLOT = 4,
  parameter int DW    = 32,
  parameter int CW    = 3,
  parameter int IW    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_root,
  input  logic                native,
  input  logic                all_full,
  input  logic [DW-1:0]       fold,
  input  logic [NSLOT*DW-1:0] slot_data,
  input  logic [CW-1:0]       count_eff,
  input  logic                up_ready,
  input  logic                root_ready,
  output logic                up_valid,
  output logic                root_valid,
  output logic [DW-1:0]       dout,
  output logic                collect_en,
  output logic                clear
);

  typedef enum logic {ST_GATHER, ST_SEND} st_e;

  st_e           st_q;
  logic          raw_q;
  logic [IW-1:0] idx_q;
  logic          upv_q;
  logic          rtv_q;
  logic [DW-1:0] dout_q;

  logic [DW-1:0] slot_arr [NSLOT];
  for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
    assign slot_arr[g] = slot_data[g*DW +: DW];
  end

  logic [IW-1:0] last_idx;
  logic [IW-1:0] nxt_idx;
  logic          accept;
  logic          done;

  assign last_idx   = IW'(count_eff - CW'(1));
  assign nxt_idx    = idx_q + IW'(1);
  assign accept     = (upv_q & up_ready) | (rtv_q & root_ready);
  assign done       = accept & (~raw_q | (idx_q == last_idx));
  assign clear      = (st_q == ST_SEND) & done;
  assign collect_en = (st_q == ST_GATHER);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_GATHER;
      raw_q <= 1'b0;
      idx_q <= '0;
      upv_q <= 1'b0;
      rtv_q <= 1'b0;
    end else begin
      case (st_q)
        ST_GATHER: begin
          if (all_full) begin
            st_q   <= ST_SEND;
            raw_q  <= ~native;
            idx_q  <= '0;
            dout_q <= native ? fold : slot_arr[0];
            upv_q  <= ~cfg_root;
            rtv_q  <= cfg_root;
          end
        end
        ST_SEND: begin
          if (done) begin
            st_q  <= ST_GATHER;
            upv_q <= 1'b0;
            rtv_q <= 1'b0;
          end else if (accept) begin
            idx_q  <= nxt_idx;
            dout_q <= slot_arr[nxt_idx];
          end
        end
        default: st_q <= ST_GATHER;
      endcase
    end
  end

  assign up_valid   = upv_q;
  assign root_valid = rtv_q;
  assign dout       = dout_q;

endmodule

// File: rtl/red_node.sv
module red_node
  import rn_pkg::*;
#(
  parameter  int NSLOT = 4,
  parameter  int DW    = 32,
  localparam int CW    = $clog2(NSLOT + 1),
  localparam int IW    = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW-1:0]       cfg_count,
  input  logic                cfg_root,
  input  logic [3:0]          cfg_op,
  input  logic [NSLOT-1:0]    in_valid,
  input  logic [NSLOT*DW-1:0] in_data,
  output logic [NSLOT-1:0]    in_ready,
  output logic                up_valid,
  output logic [DW-1:0]       up_data,
  input  logic                up_ready,
  output logic                root_valid,
  output logic [DW-1:0]       root_data,
  input  logic                root_ready
);

  logic [CW-1:0]       eff;
  logic [NSLOT-1:0]    exp_mask;
  logic [NSLOT-1:0]    full;
  logic [NSLOT*DW-1:0] slot_data;
  logic                all_full;
  logic                collect_en;
  logic                clear;
  logic [DW-1:0]       fold;
  logic [DW-1:0]       dout;

  always_comb begin
    if (cfg_count == '0)              eff = CW'(1);
    else if (cfg_count > CW'(NSLOT))  eff = CW'(NSLOT);
    else                              eff = cfg_count;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_mask
    assign exp_mask[g] = (CW'(g) < eff);
  end

  assign all_full = &(full | ~exp_mask);

  rn_slots #(.NSLOT(NSLOT), .DW(DW)) u_slots (
    .clk         (clk),
    .rst         (rst),
    .open_en     (collect_en),
    .expect_mask (exp_mask),
    .clear       (clear),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .full_o      (full),
    .data_o      (slot_data)
  );

  rn_rfu #(.NSLOT(NSLOT), .DW(DW), .CW(CW)) u_rfu (
    .op        (cfg_op),
    .count_eff (eff),
    .opnd      (slot_data),
    .res       (fold)
  );

  rn_emit #(.NSLOT(NSLOT), .DW(DW), .CW(CW), .IW(IW)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .cfg_root   (cfg_root),
    .native     (op_native(cfg_op)),
    .all_full   (all_full),
    .fold       (fold),
    .slot_data  (slot_data),
    .count_eff  (eff),
    .up_ready   (up_ready),
    .root_ready (root_ready),
    .up_valid   (up_valid),
    .root_valid (root_valid),
    .dout       (dout),
    .collect_en (collect_en),
    .clear      (clear)
  );

  assign up_data   = dout;
  assign root_data = dout;

endmodule

// File: rtl/rn_chk.sv
module rn_chk #(
  parameter  int NSLOT = 4,
  parameter  int DW    = 32,
  localparam int CW    = $clog2(NSLOT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CW-1:0]    cfg_count,
  input logic [NSLOT-1:0] in_ready,
  input logic             up_valid,
  input logic [DW-1:0]    up_data,
  input logic             up_ready,
  input logic             root_valid,
  input logic [DW-1:0]    root_data,
  input logic             root_ready
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!up_valid && !root_valid));

  for (genvar g = 1; g < NSLOT; g++) begin : g_range
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
      in_ready[g] |-> (cfg_count > CW'(g)));
  end

  assert_one_port_R8: assert property (@(posedge clk) disable iff (rst)
    !(up_valid && root_valid));

  assert_closed_R9: assert property (@(posedge clk) disable iff (rst)
    (up_valid || root_valid) |-> (in_ready == '0));

  assert_up_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_ready) |=> (up_valid && $stable(up_data)));

  assert_root_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (root_valid && !root_ready) |=> (root_valid && $stable(root_data)));

endmodule

bind red_node rn_chk #(.NSLOT(NSLOT), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_count  (cfg_count),
  .in_ready   (in_ready),
  .up_valid   (up_valid),
  .up_data    (up_data),
  .up_ready   (up_ready),
  .root_valid (root_valid),
  .root_data  (root_data),
  .root_ready (root_ready)
);

// File: tb/sim_red_node.sv
module sim_red_node;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    cfg_count;
  logic          cfg_root;
  logic [3:0]    cfg_op;
  logic [NS-1:0] in_valid;
  logic [NS*W-1:0] in_data;
  logic [NS-1:0] in_ready;
  logic          up_valid, root_valid;
  logic [W-1:0]  up_data, root_data;
  logic          up_ready = 1'b1;
  logic          root_ready = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  red_node u0 (
    .clk(clk), .rst(rst), .cfg_count(cfg_count), .cfg_root(cfg_root),
    .cfg_op(cfg_op), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .up_valid(up_valid), .up_data(up_data),
    .up_ready(up_ready), .root_valid(root_valid), .root_data(root_data),
    .root_ready(root_ready)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 0;

  typedef struct {
    logic [W-1:0] d;
    bit           to_root;
    string        req;
  } item_t;
  item_t sb_q[$];

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    up_ready   = stall_mode ? (cyc % 3 == 0) : 1'b1;
    root_ready = stall_mode ? (cyc % 3 == 1) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // monitor / scoreboard
  bit           prev_pend = 0;
  logic [W-1:0] prev_dat;
  always @(negedge clk) begin
    if (!rst) begin
      if (up_valid || root_valid) begin
        logic [W-1:0] cur;
        bit xfer;
        cur  = up_valid ? up_data : root_data;
        xfer = (up_valid && up_ready) || (root_valid && root_ready);
        chk(in_ready == '0, "R9 operands closed while output pending", W'(in_ready), 0);
        chk(!(up_valid && root_valid), "R8 both ports valid", W'(root_valid), 0);
        if (prev_pend) chk(cur == prev_dat, "R9 stalled data stable", cur, prev_dat);
        if (xfer) begin
          if (sb_q.size() == 0) chk(1'b0, "R3 output with nothing expected", cur, 0);
          else begin
            item_t e;
            e = sb_q.pop_front();
            chk(cur == e.d, e.req, cur, e.d);
            chk(root_valid == e.to_root, "R8 port selection", W'(root_valid), W'(e.to_root));
          end
        end
        prev_pend = !xfer;
        prev_dat  = cur;
      end else begin
        if (prev_pend) chk(1'b0, "R9 valid dropped without acceptance", 0, 1);
        prev_pend = 0;
      end
    end
  end

  function automatic logic [W-1:0] model(input logic [3:0] op, input int n,
                                         input logic [W-1:0] v[4]);
    logic [W-1:0] r;
    int nz;
    r = v[0];
    nz = 0;
    for (int i = 0; i < n; i++) if (v[i] != 0) nz++;
    for (int i = 1; i < n; i++) begin
      case (op)
        4'b0000: if ($signed(v[i]) > $signed(r)) r = v[i];
        4'b0001: if ($signed(v[i]) < $signed(r)) r = v[i];
        4'b0010: r = r + v[i];
        4'b0100: r = r & v[i];
        4'b0110: r = r | v[i];
        4'b1001: r = r ^ v[i];
        default: ;
      endcase
    end
    case (op)
      4'b0011: r = (nz == n) ? 1 : 0;
      4'b0101: r = (nz > 0) ? 1 : 0;
      4'b0111: r = nz[0] ? 1 : 0;
      default: ;
    endcase
    return r;
  endfunction

  function automatic bit native(input logic [3:0] op);
    return (op <= 4'b0111) || (op == 4'b1001);
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [2:0] cnt, input bit root,
                        input logic [W-1:0] v[4], input int dly[4], input bit stray,
                        input string req);
    int eff;
    logic [NS-1:0] mask, pending, taken;
    int c;
    eff = (cnt == 0) ? 1 : (cnt > 4) ? 4 : int'(cnt);
    mask = '0;
    for (int i = 0; i < eff; i++) mask[i] = 1'b1;
    cfg_op = op; cfg_count = cnt; cfg_root = root;
    if (native(op)) sb_q.push_back('{model(op, eff, v), root, req});
    else for (int i = 0; i < eff; i++)
      sb_q.push_back('{v[i], root, "R7 raw forward in slot order"});
    if (stray && eff < 4) begin
      in_valid[3] = 1'b1;
      in_data[3*W +: W] = 32'hDEAD_BEEF;
    end
    pending = mask;
    c = 0;
    while (pending != 0) begin
      @(negedge clk);
      taken = in_valid & in_ready & mask;
      if (stray && eff < 4)
        chk(in_ready[3] == 1'b0, "R2 unexpected slot not accepted", W'(in_ready[3]), 0);
      @(posedge clk); #1;
      for (int i = 0; i < NS; i++) begin
        if (taken[i]) begin
          in_valid[i] = 1'b0;
          pending[i] = 1'b0;
        end else if (pending[i] && c >= dly[i]) begin
          in_valid[i] = 1'b1;
          in_data[i*W +: W] = v[i];
        end
      end
      c++;
    end
    in_valid = '0;
    @(negedge clk);
    chk(!up_valid && !root_valid, "R3 no output in capture cycle", W'(up_valid | root_valid), 0);
    @(negedge clk);
    chk(up_valid || root_valid, "R3 output one edge after last capture", W'(up_valid | root_valid), 1);
    while (sb_q.size() != 0) @(posedge clk);
    @(negedge clk);
    chk(in_ready == mask, "R2 expected slots reopen after acceptance", W'(in_ready), W'(mask));
    @(posedge clk); #1;
  endtask

  initial begin
    logic [W-1:0] v[4];
    int d[4];
    rst = 1'b1; cfg_count = 3'd2; cfg_root = 1'b0; cfg_op = 4'b0010;
    in_valid = '0; in_data = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!up_valid && !root_valid, "R1 outputs idle after reset", W'(up_valid | root_valid), 0);
    chk(in_ready == 4'b0011, "R2 ready on expected slots after reset", W'(in_ready), 32'h3);
    @(posedge clk); #1;

    v = '{32'd10, 32'd20, 32'd30, 32'd40}; d = '{0, 0, 0, 0};
    run_op(4'b0010, 3'd4, 0, v, d, 0, "R4 sum");
    v = '{32'hFFFF_FFFF, 32'd5, 32'd3, 32'd0}; d = '{2, 0, 1, 0};
    run_op(4'b0000, 3'd3, 1, v, d, 1, "R4 signed max");
    stall_mode = 1;
    v = '{32'd3, 32'hFFFF_FFFE, 32'd8, 32'd0}; d = '{1, 3, 0, 2};
    run_op(4'b0001, 3'd4, 0, v, d, 0, "R4 signed min");
    stall_mode = 0;
    v = '{32'h7FFF_FFFF, 32'd1, 32'd0, 32'd0}; d = '{0, 1, 0, 0};
    run_op(4'b0010, 3'd2, 0, v, d, 1, "R4 sum wraps");
    v = '{32'hF0F0_FFFF, 32'hFF00_FF0F, 32'hF0FF_FF0F, 32'hFFFF_FFFF}; d = '{0, 2, 1, 3};
    run_op(4'b0100, 3'd4, 0, v, d, 0, "R5 bitwise and");
    v = '{32'd1, 32'd2, 32'd8, 32'd0};
    run_op(4'b0110, 3'd3, 1, v, d, 1, "R5 bitwise or");
    v = '{32'hFF, 32'h0F, 32'hF0, 32'h1};
    run_op(4'b1001, 3'd4, 0, v, d, 0, "R5 bitwise xor");
    v = '{32'd5, 32'hFFFF_FFFF, 32'd2, 32'd0};
    run_op(4'b0011, 3'd3, 0, v, d, 0, "R6 logical and true");
    v = '{32'd5, 32'd0, 32'd2, 32'd0};
    run_op(4'b0011, 3'd3, 1, v, d, 0, "R6 logical and false");
    v = '{32'd0, 32'd0, 32'd0, 32'd0};
    run_op(4'b0101, 3'd4, 0, v, d, 0, "R6 logical or false");
    v = '{32'd0, 32'd0, 32'h8000_0000, 32'd0};
    run_op(4'b0101, 3'd4, 0, v, d, 0, "R6 logical or true");
    v = '{32'd4, 32'd0, 32'd9, 32'd0};
    run_op(4'b0111, 3'd3, 0, v, d, 1, "R6 logical xor even");
    v = '{32'd0, 32'd0, 32'hFFFF_FFF9, 32'd0};
    run_op(4'b0111, 3'd3, 1, v, d, 0, "R6 logical xor odd");
    stall_mode = 1;
    v = '{32'd11, 32'd22, 32'd33, 32'd0}; d = '{3, 0, 1, 0};
    run_op(4'b1000, 3'd3, 0, v, d, 1, "R7 user code");
    v = '{32'hAA, 32'hBB, 32'd0, 32'd0}; d = '{1, 0, 0, 0};
    run_op(4'b1111, 3'd2, 1, v, d, 0, "R7 reserved code");
    stall_mode = 0;
    v = '{32'h40, 32'd7, 32'd7, 32'd7}; d = '{0, 0, 0, 0};
    run_op(4'b0011, 3'd0, 0, v, d, 1, "R10 count zero acts as one");
    v = '{32'd1, 32'd2, 32'd3, 32'd4};
    run_op(4'b0010, 3'd7, 1, v, d, 0, "R10 count above four acts as four");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule